// File: doc/BRIEF.md
# Static Memory Byte-Lane Strobe Generator

This block works out which byte lanes of a 32-bit external static-memory data bus are active for one access. The inputs are the transfer size code, the two low address bits, the direction, the endianness and the configured width of the target bank. The block then produces two active-low vectors. One is the lane-select strobes: they act as device write enables on byte-wide parts, or as upper/lower byte selects on wider parts. The other is the per-byte data-output enables for the write-data pads. An illegal transfer size raises an error flag.

Reads do not depend on the address. Each bank carries a lane-state configuration bit that decides how the strobes behave on a read. When the bit is clear, all four strobes stay inactive, which suits parts whose write enables hang off the strobes. When the bit is set, all four strobes are active, so that wide parts drive every byte. On writes the strobes steer the data to the addressed bytes within the bank's own lanes. The output enables drive every lane wired to the bank, so no connected data pin floats.

With `REG_OUT=1` (the default) the outputs are registered and follow the inputs by one clock. With `REG_OUT=0` the path is purely combinational.

Top module: `sm_lane_strobe`

## Requirements
- R1: While `rst_n` is low, `lane_sel_n` and `dout_en_n` are 4'hF and `size_err` is 0.
- R2: With `acc_valid` low, `lane_sel_n` and `dout_en_n` are 4'hF and `size_err` is 0, whatever the other inputs are.
- R3: A valid access with `acc_size` above 2 (codes: 0 byte, 1 halfword, 2 word) sets `size_err` to 1 and leaves `lane_sel_n` and `dout_en_n` at 4'hF, on reads and on writes alike.
- R4: A legal read (`acc_write`=0) with `rd_lanes_on`=0 gives `lane_sel_n`=4'hF, for any address and bank width.
- R5: A legal read with `rd_lanes_on`=1 gives `lane_sel_n`=4'h0, for any address and bank width. On every read `dout_en_n` is 4'hF.
- R6: Little-endian writes to a 32-bit bank (`bank_width` 2 or 3) work as follows. A byte at offset k pulls lane k low. A halfword pulls lanes 1:0 low when `acc_addr_lo[1]`=0 and lanes 3:2 low when it is 1. A word pulls all four lanes low.
- R7: Big-endian writes (`acc_big_end`=1) to a 32-bit bank mirror R6: a byte at offset k uses lane 3-k, and a halfword at offset 0 uses lanes 3:2 while one at offset 2 uses lanes 1:0.
- R8: Writes to a 16-bit bank (`bank_width`=1) use only lanes 1:0. A byte uses lane `acc_addr_lo[0]` in little-endian mode and lane 1-`acc_addr_lo[0]` in big-endian mode. Halfwords and words pull both lanes low.
- R9: Every write to an 8-bit bank (`bank_width`=0) pulls only lane 0 low.
- R10: On a legal write, `dout_en_n` is low on exactly the lanes wired to the bank: lane 0 for 8-bit, lanes 1:0 for 16-bit and all four lanes for 32-bit.
- R11: With `REG_OUT=1`, the outputs show the result for the inputs present at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is being presented |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_big_end | input | 1 | 1 = big-endian byte ordering |
| acc_size | input | 3 | Transfer size code: 0 byte, 1 halfword, 2 word, others illegal |
| acc_addr_lo | input | 2 | Address bits [1:0] of the access |
| bank_width | input | 2 | Bank width: 0 = 8, 1 = 16, 2 or 3 = 32 bits |
| rd_lanes_on | input | 1 | Bank lane-state bit: strobe level on reads |
| lane_sel_n | output | 4 | Active-low byte-lane strobes, bit n for data byte n |
| dout_en_n | output | 4 | Active-low write-data pad enables, bit n for bits 8n+7:8n |
| size_err | output | 1 | Illegal transfer size on a valid access |

## Verification
The cases that are hardest to reach from the ports are the ones where several inputs mask each other. Examples are a halfword at an odd offset, a word into a 16-bit bank, a big-endian byte into an 8-bit bank, the reserved width code 3, and an illegal size that arrives together with a set lane-state bit on a read. The stimulus therefore walks every combination of valid, direction, endianness, size code, address, width code and lane-state bit, one per clock. A behavioural model computes the expected lanes from byte positions, and its result is compared one cycle later.

// File: rtl/sm_lane_pkg.sv
package sm_lane_pkg;
  localparam int LANES = 4;
  localparam int SIZE_W = 3;
  localparam logic [SIZE_W-1:0] SZ_BYTE = 3'd0;
  localparam logic [SIZE_W-1:0] SZ_HALF = 3'd1;
  localparam logic [SIZE_W-1:0] SZ_MAX  = 3'd2;

  typedef logic [LANES-1:0] lane_vec_t;

  typedef enum logic [1:0] {
    BW_8   = 2'd0,
    BW_16  = 2'd1,
    BW_32  = 2'd2,
    BW_32R = 2'd3
  } bank_w_e;
endpackage

// File: rtl/sm_wr_steer.sv
// Active-high mask of lanes strobed by a legal write beat.
module sm_wr_steer
  import sm_lane_pkg::*;
(
  input  logic [1:0] size_i,
  input  logic [1:0] addr_i,
  input  logic       big_i,
  input  bank_w_e    width_i,
  output lane_vec_t  mask_o
);
  lane_vec_t le32;
  lane_vec_t le16;

  // Little-endian placement in a 32-bit bank.
  always_comb begin
    if (size_i == SZ_BYTE[1:0])      le32 = lane_vec_t'(1) << addr_i;
    else if (size_i == SZ_HALF[1:0]) le32 = addr_i[1] ? 4'b1100 : 4'b0011;
    else                             le32 = 4'b1111;
  end

  // Little-endian placement in a 16-bit bank.
  always_comb begin
    if (size_i == SZ_BYTE[1:0]) le16 = addr_i[0] ? 4'b0010 : 4'b0001;
    else                        le16 = 4'b0011;
  end

  always_comb begin
    unique case (width_i)
      BW_8:  mask_o = 4'b0001;
      BW_16: mask_o = big_i ? {2'b00, le16[0], le16[1]} : le16;
      default: begin
        for (int i = 0; i < LANES; i++)
          mask_o[i] = big_i ? le32[LANES-1-i] : le32[i];
      end
    endcase
  end
endmodule

// File: rtl/sm_drive_mask.sv
// Active-high mask of data lanes physically wired to the bank.
module sm_drive_mask
  import sm_lane_pkg::*;
(
  input  bank_w_e   width_i,
  output lane_vec_t drive_o
);
  always_comb begin
    unique case (width_i)
      BW_8:    drive_o = 4'b0001;
      BW_16:   drive_o = 4'b0011;
      default: drive_o = 4'b1111;
    endcase
  end
endmodule

// File: rtl/sm_out_stage.sv
// Optional output register; reset value is the idle (all inactive) state.
module sm_out_stage
  import sm_lane_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  lane_vec_t sel_d,
  input  lane_vec_t oe_d,
  input  logic      err_d,
  output lane_vec_t sel_q,
  output lane_vec_t oe_q,
  output logic      err_q
);
  generate
    if (REG_OUT) begin : g_reg
      lane_vec_t sel_r, oe_r;
      logic      err_r;
      logic      load_en;

      assign load_en = 1'b1;  // register follows every cycle

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sel_r <= '1;
          oe_r  <= '1;
          err_r <= 1'b0;
        end else if (load_en) begin
          sel_r <= sel_d;
          oe_r  <= oe_d;
          err_r <= err_d;
        end
      end

      assign sel_q = sel_r;
      assign oe_q  = oe_r;
      assign err_q = err_r;
    end else begin : g_comb
      assign sel_q = sel_d;
      assign oe_q  = oe_d;
      assign err_q = err_d;
    end
  endgenerate
endmodule

// File: rtl/sm_lane_strobe.sv
module sm_lane_strobe
  import sm_lane_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_valid,
  input  logic       acc_write,
  input  logic       acc_big_end,
  input  logic [2:0] acc_size,
  input  logic [1:0] acc_addr_lo,
  input  logic [1:0] bank_width,
  input  logic       rd_lanes_on,
  output logic [3:0] lane_sel_n,
  output logic [3:0] dout_en_n,
  output logic       size_err
);
  bank_w_e   width;
  logic      size_bad;
  lane_vec_t wr_mask, drv_mask;
  lane_vec_t sel_nxt, oe_nxt;
  logic      err_nxt;

  assign width    = bank_w_e'(bank_width);
  assign size_bad = acc_size > SZ_MAX;

  sm_wr_steer u_steer (
    .size_i  (acc_size[1:0]),
    .addr_i  (acc_addr_lo),
    .big_i   (acc_big_end),
    .width_i (width),
    .mask_o  (wr_mask)
  );

  sm_drive_mask u_drive (
    .width_i (width),
    .drive_o (drv_mask)
  );

  // Next-state selection of the strobes and pad enables.
  always_comb begin
    sel_nxt = '1;
    oe_nxt  = '1;
    err_nxt = 1'b0;
    if (acc_valid) begin
      if (size_bad) begin
        err_nxt = 1'b1;
      end else if (acc_write) begin
        sel_nxt = ~wr_mask;
        oe_nxt  = ~drv_mask;
      end else begin
        sel_nxt = rd_lanes_on ? '0 : '1;
      end
    end
  end

  sm_out_stage #(.REG_OUT(REG_OUT)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .sel_d (sel_nxt),
    .oe_d  (oe_nxt),
    .err_d (err_nxt),
    .sel_q (lane_sel_n),
    .oe_q  (dout_en_n),
    .err_q (size_err)
  );

  // Checks on the logic above.
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (sel_nxt == 4'hF && oe_nxt == 4'hF && !err_nxt));

  assert_err_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    size_err |-> (lane_sel_n == 4'hF && dout_en_n == 4'hF));

  // R4 and R5: read strobes are uniform, pads are never driven on reads.
  assert_read_uniform_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write) |-> ((sel_nxt == 4'h0 || sel_nxt == 4'hF) && oe_nxt == 4'hF));

  assert_byte_one_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_size == 3'd0) |-> $countones(~sel_nxt) == 1);

  assert_narrow_lane0_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && !size_bad && width == BW_8) |-> sel_nxt == 4'b1110);

  assert_strobe_driven_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((~sel_nxt & oe_nxt) == 4'h0) || !(acc_valid && acc_write));

  assert_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    REG_OUT && $past(rst_n) |-> ##0 (lane_sel_n == $past(sel_nxt)));
endmodule

// File: tb/sm_lane_strobe_bench.sv
module sm_lane_strobe_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       acc_valid, acc_write, acc_big_end, rd_lanes_on;
  logic [2:0] acc_size;
  logic [1:0] acc_addr_lo, bank_width;
  logic [3:0] lane_sel_n, dout_en_n;
  logic       size_err;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sm_lane_strobe u_sm_lane_strobe (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_big_end(acc_big_end), .acc_size(acc_size), .acc_addr_lo(acc_addr_lo),
    .bank_width(bank_width), .rd_lanes_on(rd_lanes_on),
    .lane_sel_n(lane_sel_n), .dout_en_n(dout_en_n), .size_err(size_err)
  );

  // Behavioural model: {err, sel[3:0], oe[3:0]} from byte positions.
  function automatic logic [8:0] model(int v, int w, int big, int sz, int ad, int wd, int ls);
    logic [3:0] sel = 4'hF;
    logic [3:0] oe  = 4'hF;
    logic       err = 1'b0;
    if (v != 0) begin
      if (sz > 2) err = 1'b1;
      else if (w == 0) sel = (ls != 0) ? 4'h0 : 4'hF;
      else begin
        int wb  = (wd == 0) ? 1 : (wd == 1) ? 2 : 4;
        int sb  = 1 << sz;
        int off;
        if (sb > wb) sb = wb;
        off = ((ad % wb) / sb) * sb;
        for (int i = 0; i < sb; i++) begin
          int p = off + i;
          sel[(big != 0) ? (wb - 1 - p) : p] = 1'b0;
        end
        for (int j = 0; j < wb; j++) oe[j] = 1'b0;
      end
    end
    return {err, sel, oe};
  endfunction

  function automatic string tag_of(int v, int w, int big, int sz, int wd, int ls);
    if (v == 0) return "R2";
    if (sz > 2) return "R3";
    if (w == 0) return (ls != 0) ? "R5" : "R4";
    if (wd == 0) return "R9";
    if (wd == 1) return "R8";
    if (big != 0) return "R7";
    return "R6";
  endfunction

  task automatic check(string tag, logic [4:0] got, logic [4:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    acc_valid = 1'b1; acc_write = 1'b1; acc_big_end = 1'b0; rd_lanes_on = 1'b1;
    acc_size = 3'd2; acc_addr_lo = 2'd0; bank_width = 2'd2;
    repeat (3) @(negedge clk);
    // R1: reset holds everything inactive even with a live access on the inputs.
    check("R1", {size_err, lane_sel_n}, 5'b0_1111);
    check("R1", {1'b0, dout_en_n}, 5'b0_1111);
    rst_n = 1'b1;
    acc_valid = 1'b0;
    @(negedge clk);
    begin
      logic [8:0] prev_exp = 9'b0_1111_1111;
      string      prev_tag = "R2";
      logic       prev_wr  = 1'b0;
      for (int v = 0; v < 2; v++)
      for (int w = 0; w < 2; w++)
      for (int big = 0; big < 2; big++)
      for (int sz = 0; sz < 8; sz++)
      for (int ad = 0; ad < 4; ad++)
      for (int wd = 0; wd < 4; wd++)
      for (int ls = 0; ls < 2; ls++) begin
        // R11: result of the vector driven one edge earlier is checked here.
        check(prev_tag, {size_err, lane_sel_n}, {prev_exp[8], prev_exp[7:4]});
        check(prev_wr ? "R10" : prev_tag, {1'b0, dout_en_n}, {1'b0, prev_exp[3:0]});
        acc_valid = v[0]; acc_write = w[0]; acc_big_end = big[0];
        acc_size = sz[2:0]; acc_addr_lo = ad[1:0]; bank_width = wd[1:0];
        rd_lanes_on = ls[0];
        prev_exp = model(v, w, big, sz, ad, wd, ls);
        prev_tag = tag_of(v, w, big, sz, wd, ls);
        prev_wr  = (v != 0) && (w != 0) && (sz <= 2);
        @(negedge clk);
      end
      check(prev_tag, {size_err, lane_sel_n}, {prev_exp[8], prev_exp[7:4]});
      check(prev_wr ? "R10" : prev_tag, {1'b0, dout_en_n}, {1'b0, prev_exp[3:0]});
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule